// File: doc/BRIEF.md
# Keyed Watchdog and Interval Timer

This block supervises software with a free-running counter. Software has to restart the counter before it reaches a selected limit. If it does not, the block sends a one-cycle soft reset request to the system reset logic. The same counter can run as a plain periodic interval timer instead. In that mode a timeout only sets a flag and, when enabled, requests an interrupt. The counter then wraps to zero and keeps counting.

The block has a single 16-bit control register on a write strobe and data bus. A write changes the register only when its upper byte carries the unlock key. A write with any other upper byte is treated as a software fault and produces a soft reset request. Two clock-enable inputs stand for a fast and a slow timing source, and a control bit chooses between them.

The control bits and the timeout flag are cleared only by the power-on reset input. Both survive the soft reset that the block requests, so software can read the flag afterwards to learn why the reset happened.

Top module: `guard_timer`

## Requirements
- R1: A write with `busWdata[15:8]` equal to 0x5A loads the control bits from the lower byte. The lower byte is laid out as follows: bit0 holds the counter, bit1 selects interval mode, bit2 selects the slow tick, bit3 clears the counter, bits5:4 select the tap, and bit6 enables the interrupt.
- R2: A write whose upper byte is not 0x5A leaves the control bits unchanged. It pulses `softRstReq` for exactly one cycle, in the cycle after the write.
- R3: `busRdata` always returns 0x69 in its upper byte and the stored control bits in its lower byte. Bit3 and bit7 always read as 0.
- R4: The timeout period is counted in ticks of the selected source. Tap code 0 gives 32768 ticks (the reset default), code 1 gives 8192, code 2 gives 512 and code 3 gives 64.
- R5: With bit2 = 0 the counter advances on `tickFast`, which is the reset default. With bit2 = 1 it advances only on `tickSlow`.
- R6: A keyed write with bit3 = 1 sets the counter to zero, so the next timeout comes one full period after that write.
- R7: While bit0 = 1 the counter does not advance and no timeout occurs.
- R8: In watchdog mode (bit1 = 0), the last tick of a period does three things. It sets `timeoutFlag`, it pulses `softRstReq` for one cycle after that tick's edge, and it restarts the counter from zero.
- R9: In interval mode (bit1 = 1), a timeout sets `timeoutFlag` and produces no `softRstReq`. The counter wraps to zero, so timeouts repeat once per period.
- R10: `irqReq` is high only when the flag is set, bit6 = 1 and bit1 = 1. A pulse on `irqAck` clears the flag in interval mode and has no effect on the flag in watchdog mode.
- R11: Driving `porN` low clears the control bits, the flag and the counter. The block's own soft reset request changes none of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| porN | input | 1 | Power-on reset, asynchronous, active low |
| tickFast | input | 1 | Count enable of the fast timing source |
| tickSlow | input | 1 | Count enable of the slow timing source |
| busWr | input | 1 | Control register write strobe |
| busWdata | input | 16 | Write data: key in the upper byte, control bits in the lower byte |
| busRdata | output | 16 | Read data: tag byte and control bits |
| irqAck | input | 1 | Interrupt acknowledge pulse |
| irqReq | output | 1 | Interrupt request |
| timeoutFlag | output | 1 | Timeout flag, kept through soft reset |
| softRstReq | output | 1 | One-cycle soft reset request |

## Verification
The assertions check several rules on every cycle: a keyed write loads the register, an unkeyed write leaves it intact and raises the reset request, every timeout sets the flag, the flag falls only on an acknowledge in interval mode, a clear zeroes the counter, and a held counter stays still. Other behaviour can only be shown by the bench's scenarios. These are the exact length of each of the four periods measured from a clear, the choice between the two tick sources, the wrap and repeat in interval mode, and the rule that a reset pulse lasts one cycle and never appears unexpectedly. The same holds for the flag surviving a timeout while it is cleared by power-on reset.

// File: rtl/guard_pkg.sv
package guard_pkg;
  // Strobes and settings sent from the register control to the counter datapath
  typedef struct packed {
    logic       clear;    // restart the counter from zero
    logic       run;      // counting allowed
    logic       useSlow;  // advance on the slow tick
    logic [1:0] tapSel;   // period select code
  } coreCmd_t;

  localparam int CTRL_W = 16;
  localparam int BYTE_W = 8;
endpackage

// File: rtl/guard_core.sv
module guard_core
  import guard_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int TAP0  = 15,
  parameter int TAP1  = 13,
  parameter int TAP2  = 9,
  parameter int TAP3  = 6
) (
  input  logic     clk,
  input  logic     porN,
  input  logic     tickFast,
  input  logic     tickSlow,
  input  coreCmd_t cmd,
  output logic     hit
);
  localparam int NUM_TAPS = 4;
  localparam int TAPS [NUM_TAPS] = '{TAP0, TAP1, TAP2, TAP3};

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limitTab [NUM_TAPS];
  logic [CNT_W-1:0] lastVal;
  logic             tick;
  logic             step;

  // The last count value of each period is computed from the tap position
  for (genvar gi = 0; gi < NUM_TAPS; gi++) begin : g_limit
    assign limitTab[gi] = CNT_W'((64'd1 << TAPS[gi]) - 64'd1);
  end

  assign tick    = cmd.useSlow ? tickSlow : tickFast;
  assign step    = tick & cmd.run;
  assign lastVal = limitTab[cmd.tapSel];
  assign hit     = step & ~cmd.clear & (cnt >= lastVal);

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)          cnt <= '0;
    else if (cmd.clear) cnt <= '0;
    else if (hit)       cnt <= '0;
    else if (step)      cnt <= cnt + 1'b1;
  end

  // R6: a clear strobe leaves the counter at zero
  assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!porN)
    cmd.clear |=> (cnt == '0));

  // R7: a stopped counter keeps its value
  assert_hold_still_R7: assert property (@(posedge clk) disable iff (!porN)
    (!cmd.run && !cmd.clear) |=> $stable(cnt));

  // R8: every timeout restarts the period
  assert_restart_R8: assert property (@(posedge clk) disable iff (!porN)
    hit |=> (cnt == '0));
endmodule

// File: rtl/guard_ctrl.sv
module guard_ctrl
  import guard_pkg::*;
#(
  parameter logic [BYTE_W-1:0] KEY = 8'h5A,
  parameter logic [BYTE_W-1:0] TAG = 8'h69
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              busWr,
  input  logic [CTRL_W-1:0] busWdata,
  output logic [CTRL_W-1:0] busRdata,
  input  logic              irqAck,
  input  logic              hit,
  output coreCmd_t          cmd,
  output logic              irqReq,
  output logic              timeoutFlag,
  output logic              softRstReq
);
  localparam int B_HOLD = 0;
  localparam int B_IVL  = 1;
  localparam int B_SLOW = 2;
  localparam int B_CLR  = 3;
  localparam int B_TAP  = 4;
  localparam int B_IEN  = 6;

  logic       hold;
  logic       intervalMode;
  logic       useSlow;
  logic [1:0] tapSel;
  logic       irqEn;
  logic       keyOk;
  logic       goodWr;
  logic       badWr;
  logic       unusedSpare;

  assign keyOk       = (busWdata[CTRL_W-1:BYTE_W] == KEY);
  assign goodWr      = busWr & keyOk;
  assign badWr       = busWr & ~keyOk;
  assign unusedSpare = busWdata[7];

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      hold         <= 1'b0;
      intervalMode <= 1'b0;
      useSlow      <= 1'b0;
      tapSel       <= 2'b00;
      irqEn        <= 1'b0;
    end else if (goodWr) begin
      hold         <= busWdata[B_HOLD];
      intervalMode <= busWdata[B_IVL];
      useSlow      <= busWdata[B_SLOW];
      tapSel       <= busWdata[B_TAP+1:B_TAP];
      irqEn        <= busWdata[B_IEN];
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      timeoutFlag <= 1'b0;
      softRstReq  <= 1'b0;
    end else begin
      softRstReq <= (hit & ~intervalMode) | badWr;
      if (hit)                        timeoutFlag <= 1'b1;
      else if (irqAck & intervalMode) timeoutFlag <= 1'b0;
    end
  end

  assign cmd.clear   = goodWr & busWdata[B_CLR];
  assign cmd.run     = ~hold;
  assign cmd.useSlow = useSlow;
  assign cmd.tapSel  = tapSel;

  assign irqReq   = timeoutFlag & irqEn & intervalMode;
  assign busRdata = {TAG, 1'b0, irqEn, tapSel, 1'b0, useSlow, intervalMode, hold};

  // R1: a keyed write lands in the register (clear bit and spare bit read 0)
  assert_key_write_R1: assert property (@(posedge clk) disable iff (!porN)
    goodWr |=> (busRdata[7:0] == ($past(busWdata[7:0]) & 8'h77)));

  // R2: an unkeyed write leaves the register and raises the reset request
  assert_bad_key_R2: assert property (@(posedge clk) disable iff (!porN)
    badWr |=> (softRstReq && $stable(busRdata)));

  // R8: a timeout always sets the flag
  assert_flag_set_R8: assert property (@(posedge clk) disable iff (!porN)
    hit |=> timeoutFlag);

  // R9: interval timeouts never request a reset
  assert_interval_quiet_R9: assert property (@(posedge clk) disable iff (!porN)
    (hit && intervalMode && !badWr) |=> !softRstReq);

  // R10: the flag only falls on an acknowledge in interval mode
  assert_flag_fall_R10: assert property (@(posedge clk) disable iff (!porN)
    $fell(timeoutFlag) |-> ($past(irqAck) && $past(intervalMode)));
endmodule

// File: rtl/guard_timer.sv
module guard_timer
  import guard_pkg::*;
#(
  parameter int                CNT_W = 16,
  parameter logic [BYTE_W-1:0] KEY   = 8'h5A,
  parameter logic [BYTE_W-1:0] TAG   = 8'h69
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              tickFast,
  input  logic              tickSlow,
  input  logic              busWr,
  input  logic [CTRL_W-1:0] busWdata,
  output logic [CTRL_W-1:0] busRdata,
  input  logic              irqAck,
  output logic              irqReq,
  output logic              timeoutFlag,
  output logic              softRstReq
);
  coreCmd_t cmd;
  logic     hit;

  guard_ctrl #(.KEY(KEY), .TAG(TAG)) u_ctrl (
    .clk        (clk),
    .porN       (porN),
    .busWr      (busWr),
    .busWdata   (busWdata),
    .busRdata   (busRdata),
    .irqAck     (irqAck),
    .hit        (hit),
    .cmd        (cmd),
    .irqReq     (irqReq),
    .timeoutFlag(timeoutFlag),
    .softRstReq (softRstReq)
  );

  guard_core #(.CNT_W(CNT_W)) u_core (
    .clk     (clk),
    .porN    (porN),
    .tickFast(tickFast),
    .tickSlow(tickSlow),
    .cmd     (cmd),
    .hit     (hit)
  );
endmodule

// File: tb/sim_guard_timer.sv
`timescale 1ns/1ps
module sim_guard_timer;
  logic        clk = 1'b0;
  logic        porN = 1'b0;
  logic        tickFast = 1'b0;
  logic        tickSlow = 1'b0;
  logic        busWr = 1'b0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic        irqAck = 1'b0;
  logic        irqReq;
  logic        timeoutFlag;
  logic        softRstReq;

  int runCnt = 0;
  int failCnt = 0;
  int cyc = 0;
  int pulseCnt = 0;
  int expQ[$];

  always #10 clk = ~clk;  // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  guard_timer u0 (
    .clk(clk), .porN(porN), .tickFast(tickFast), .tickSlow(tickSlow),
    .busWr(busWr), .busWdata(busWdata), .busRdata(busRdata),
    .irqAck(irqAck), .irqReq(irqReq), .timeoutFlag(timeoutFlag),
    .softRstReq(softRstReq)
  );

  task automatic check(input string req, input int act, input int exp);
    runCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Monitor: every reset pulse must match the next expected cycle (R2, R8)
  always @(negedge clk) begin
    if (porN && softRstReq) begin
      pulseCnt++;
      runCnt++;
      if (expQ.size() == 0) begin
        failCnt++;
        $display("FAIL R2/R8: unexpected softRstReq at cycle %0d (actual 1 expected 0)", cyc);
      end else begin
        int e;
        e = expQ.pop_front();
        if (e != cyc) begin
          failCnt++;
          $display("FAIL R2/R8: softRstReq at cycle %0d expected %0d", cyc, e);
        end
      end
    end
  end

  // Driver: one write; a pulse is expected dly cycles after the write edge (dly < 0: none)
  task automatic busWrite(input logic [15:0] d, input int dly);
    @(negedge clk);
    if (dly >= 0) expQ.push_back(cyc + 1 + dly);
    busWr = 1'b1;
    busWdata = d;
    @(negedge clk);
    busWr = 1'b0;
    busWdata = '0;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitUntil(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic ack();
    irqAck = 1'b1;
    @(negedge clk);
    irqAck = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    failCnt++;
    $display("FAIL watchdog: run did not finish (actual hung expected done)");
    $display("  [TB] %0d tests run, %0d failed", runCnt, failCnt);
    $finish;
  end

  initial begin
    int c0;
    int pc;
    waitCyc(3);
    porN = 1'b1;
    waitCyc(2);
    // R3/R11: reset state
    check("R3 reset read", busRdata, 16'h6900);
    check("R11 reset flag", timeoutFlag, 0);
    check("R10 reset irq", irqReq, 0);

    // R4/R5/R8: default period 32768 on the fast tick
    tickFast = 1'b1;
    busWrite(16'h5A08, 32768);
    waitCyc(32770);
    check("R8 flag after timeout", timeoutFlag, 1);
    check("R11 control kept through soft reset", busRdata, 16'h6900);
    busWrite(16'h5A01, -1);

    // R4: remaining taps
    busWrite(16'h5A28, 512);
    waitCyc(515);
    busWrite(16'h5A01, -1);
    busWrite(16'h5A18, 8192);
    waitCyc(8195);
    busWrite(16'h5A01, -1);
    busWrite(16'h5A38, 64);
    check("R3 clear bit reads 0", busRdata, 16'h6930);
    waitCyc(67);
    busWrite(16'h5A01, -1);

    // R6: a clear part-way restarts the period
    busWrite(16'h5A38, -1);
    waitCyc(40);
    busWrite(16'h5A38, 64);
    waitCyc(70);
    busWrite(16'h5A01, -1);

    // R7: hold blocks timeouts
    pc = pulseCnt;
    busWrite(16'h5A39, -1);
    waitCyc(200);
    check("R7 no pulse while held", pulseCnt - pc, 0);
    check("R1 held config read", busRdata, 16'h6931);

    // R5: slow source selected, fast ticks ignored
    pc = pulseCnt;
    busWrite(16'h5A3C, -1);
    waitCyc(100);
    check("R5 fast tick ignored", pulseCnt - pc, 0);
    expQ.push_back(cyc + 64);
    tickSlow = 1'b1;
    waitCyc(70);
    check("R5 slow tick timeout", pulseCnt - pc, 1);
    busWrite(16'h5A35, -1);
    tickSlow = 1'b0;

    // R2: wrong key
    pc = pulseCnt;
    busWrite(16'h1234, 0);
    waitCyc(3);
    check("R2 register unchanged", busRdata, 16'h6935);
    check("R2 one pulse", pulseCnt - pc, 1);

    // R10: acknowledge ignored in watchdog mode
    ack();
    check("R10 ack ignored in watchdog mode", timeoutFlag, 1);
    check("R10 no irq in watchdog mode", irqReq, 0);

    // R9/R10: interval mode
    pc = pulseCnt;
    busWrite(16'h5A7A, -1);
    c0 = cyc;
    check("R10 irq with old flag", irqReq, 1);
    ack();
    check("R10 ack clears flag", timeoutFlag, 0);
    check("R10 irq low after ack", irqReq, 0);
    waitUntil(c0 + 63);
    check("R9 flag before period end", timeoutFlag, 0);
    @(negedge clk);
    check("R9 flag at period end", timeoutFlag, 1);
    check("R10 irq raised", irqReq, 1);
    ack();
    waitUntil(c0 + 127);
    check("R9 flag before wrap period end", timeoutFlag, 0);
    @(negedge clk);
    check("R9 flag after wrap", timeoutFlag, 1);
    check("R9 no reset in interval mode", pulseCnt - pc, 0);

    // R10: enable off
    busWrite(16'h5A3A, -1);
    check("R10 irq masked", irqReq, 0);
    check("R10 flag still set", timeoutFlag, 1);

    // R11: power-on reset clears all
    tickFast = 1'b0;
    @(negedge clk);
    porN = 1'b0;
    waitCyc(2);
    porN = 1'b1;
    waitCyc(2);
    check("R11 control cleared", busRdata, 16'h6900);
    check("R11 flag cleared", timeoutFlag, 0);
    check("R2/R8 no pulse left pending", expQ.size(), 0);

    $display("  [TB] %0d tests run, %0d failed", runCnt, failCnt);
    $finish;
  end
endmodule